// File: doc/BRIEF.md
# Add-on Board Colour, Serial and Joystick Port Registers

This block sits on the CPU I/O bus of an add-on board. It decodes I/O reads and writes and holds two small registers. The first is a colour control register that sets the colour enable, the attribute source mode and a 4-bit border colour. The second is a serial-line register that holds the transmit data and handshake levels. A configuration switch can lock the colour register to a fixed monochrome value, and a second switch turns the serial port on or off.

On reads the block does not own the whole data bus. It returns a byte together with a per-bit drive mask. Colour-port reads drive a single presence flag, and serial-port reads drive the received data, the handshake and a presence bit. A five-button cursor joystick is merged into keyboard-row reads. It only ever pulls bits low, and it does so on ports that are decoded from a few address lines.

Top module: `board_io_regs`

## Requirements
- R1: A write (iorq_n=0, wr_n=0) to address 0x7FEF while sw_color=1 loads the register at the next clock edge: color_en = data bit 5, color_attr_mode = data bit 4, border_color = data bits 3:0. A write to any other address leaves these outputs unchanged.
- R2: While sw_color=0 the colour register is forced to 0x0F (color_en=0, color_attr_mode=0, border_color=0xF) from the next clock edge on, and writes to 0x7FEF are ignored. When sw_color returns to 1, the register keeps 0x0F until it is written.
- R3: A read (iorq_n=0, rd_n=0) of 0x7FEF gives rd_drive=0x20, with rd_data bit 5 = 0 when sw_color=1 and 1 when sw_color=0.
- R4: Address 0xFEEF is decoded on all 16 bits and responds only when sw_serial=1. A write loads data bits 1:0. ser_tx_line then equals the inverse of bit 0, and ser_rts_out equals bit 1 (1 = ok to send).
- R5: A read of 0xFEEF with sw_serial=1 gives rd_drive=0xC1. rd_data bit 7 is the inverse of ser_rx_line, bit 6 is ser_cts_in and bit 0 is 0 (port present).
- R6: Reset, or sw_serial=0 from the next clock edge on, puts the serial lines in the idle state (ser_tx_line=1, ser_rts_out=0). Writes to 0xFEEF are ignored while sw_serial=0.
- R7: On a read with address bit 0 = 0, joy_btn (bit0 right, bit1 left, bit2 down, bit3 up, bit4 fire; 1 = pressed) pulls bits low as follows. When address bit 11 = 0, left pulls bit 4. When address bit 12 = 0, right pulls bit 2, up pulls bit 3, down pulls bit 4 and fire pulls bit 0.
- R8: The joystick drives only zeros: rd_drive marks exactly the bits pulled by pressed buttons, and every bit that is not driven reads 1 on rd_data.
- R9: After reset, color_en=0, color_attr_mode=0 and border_color=0xF.
- R10: rd_drive is 0 whenever there is no I/O read, or the read hits no port of this block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | 16 | CPU I/O address |
| io_wdata | input | 8 | CPU write data |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sw_color | input | 1 | Colour modes switch (1 = available) |
| sw_serial | input | 1 | Serial port switch (1 = on) |
| joy_btn | input | 5 | Joystick buttons: fire, up, down, left, right (bit 4 to bit 0), 1 = pressed |
| ser_rx_line | input | 1 | Received serial line level, 1 = idle |
| ser_cts_in | input | 1 | Incoming handshake, 1 = ok to send |
| rd_data | output | 8 | Read data contribution |
| rd_drive | output | 8 | Per-bit mask of the bits this block drives |
| color_en | output | 1 | Colour enable |
| color_attr_mode | output | 1 | Attribute source mode |
| border_color | output | 4 | Border colour |
| ser_tx_line | output | 1 | Transmit line level, 1 = idle |
| ser_rts_out | output | 1 | Outgoing handshake, 1 = ok to send |

## Verification
The read path is tried with a table of addresses. The table covers the two exact ports, one address that differs from the serial port by a single bit, and joystick rows where address bit 11, bit 12, both or neither are low. This shows whether the decode is partial or full and which button lands on which bit. Button sets are chosen so that a button belonging to the other row must produce no pull. Directed sequences then toggle each switch around writes, which tells apart a lock that forces the register from one that only masks the outputs, and tells apart ignored writes from writes that are applied late.

// File: rtl/board_io_pkg.sv
package board_io_pkg;

  localparam int DATA_W = 8;
  localparam int JOY_N  = 5;

  // joystick button positions
  localparam int BTN_RIGHT = 0;
  localparam int BTN_LEFT  = 1;
  localparam int BTN_DOWN  = 2;
  localparam int BTN_UP    = 3;
  localparam int BTN_FIRE  = 4;

  typedef struct packed {
    logic       en;
    logic       mode;
    logic [3:0] border;
  } color_cfg_t;

  localparam color_cfg_t COLOR_LOCKED = '{en: 1'b0, mode: 1'b0, border: 4'hF};

  // byte returned by the colour port: bit 5 low when colour is available
  function automatic logic [DATA_W-1:0] color_status(input logic avail);
    color_status = {2'b11, ~avail, 5'b11111};
  endfunction

  // byte returned by the serial port
  function automatic logic [DATA_W-1:0] serial_status(input logic rx_line,
                                                      input logic cts);
    serial_status = {~rx_line, cts, 5'b11111, 1'b0};
  endfunction

  // bits pulled low by the joystick for a keyboard-row read
  function automatic logic [DATA_W-1:0] joy_pull(input logic row_a11_n,
                                                 input logic row_a12_n,
                                                 input logic [JOY_N-1:0] btn);
    logic [DATA_W-1:0] m;
    m = '0;
    if (!row_a11_n) m[4] = btn[BTN_LEFT];
    if (!row_a12_n) begin
      m[0] = btn[BTN_FIRE];
      m[2] = btn[BTN_RIGHT];
      m[3] = btn[BTN_UP];
      m[4] = m[4] | btn[BTN_DOWN];
    end
    joy_pull = m;
  endfunction

endpackage

// File: rtl/color_ctrl_reg.sv
module color_ctrl_reg
  import board_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              unlock,
  output color_cfg_t        cfg
);
  color_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= COLOR_LOCKED;
    else if (!unlock) cfg_q <= COLOR_LOCKED;
    else if (wr_hit) cfg_q <= '{en: wdata[5], mode: wdata[4], border: wdata[3:0]};
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/serial_line_reg.sv
module serial_line_reg
  import board_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  input  logic              port_on,
  output logic              tx_line,
  output logic              rts
);
  logic [1:0] bits_q;   // [1] handshake, [0] inverted data

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        bits_q <= 2'b00;
    else if (!port_on) bits_q <= 2'b00;
    else if (wr_hit)   bits_q <= wdata[1:0];
  end

  assign tx_line = ~bits_q[0];
  assign rts     = bits_q[1];
endmodule

// File: rtl/joy_row_decode.sv
module joy_row_decode
  import board_io_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_active,
  input  logic [JOY_N-1:0]  btn,
  output logic              row_sel,
  output logic [DATA_W-1:0] pull
);
  assign row_sel = rd_active && !addr[0];
  assign pull    = row_sel ? joy_pull(addr[11], addr[12], btn) : '0;
endmodule

// File: rtl/board_io_regs.sv
module board_io_regs
  import board_io_pkg::*;
#(
  parameter int              ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] COLOR_PORT  = 16'h7FEF,
  parameter logic [ADDR_W-1:0] SERIAL_PORT = 16'hFEEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              sw_color,
  input  logic              sw_serial,
  input  logic [JOY_N-1:0]  joy_btn,
  input  logic              ser_rx_line,
  input  logic              ser_cts_in,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] rd_drive,
  output logic              color_en,
  output logic              color_attr_mode,
  output logic [3:0]        border_color,
  output logic              ser_tx_line,
  output logic              ser_rts_out
);
  localparam logic [DATA_W-1:0] COLOR_MASK  = 8'h20;
  localparam logic [DATA_W-1:0] SERIAL_MASK = 8'hC1;

  // named events for the checker
  logic rd_active, wr_active, color_hit, serial_hit, joy_row;
  logic [DATA_W-1:0] joy_mask;
  color_cfg_t cfg;

  assign rd_active  = !iorq_n && !rd_n;
  assign wr_active  = !iorq_n && !wr_n;
  assign color_hit  = (io_addr == COLOR_PORT);
  assign serial_hit = (io_addr == SERIAL_PORT) && sw_serial;

  color_ctrl_reg u_color (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_hit (wr_active && color_hit),
    .wdata  (io_wdata),
    .unlock (sw_color),
    .cfg    (cfg)
  );

  serial_line_reg u_serial (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (wr_active && serial_hit),
    .wdata   (io_wdata),
    .port_on (sw_serial),
    .tx_line (ser_tx_line),
    .rts     (ser_rts_out)
  );

  joy_row_decode #(.ADDR_W(ADDR_W)) u_joy (
    .addr      (io_addr),
    .rd_active (rd_active),
    .btn       (joy_btn),
    .row_sel   (joy_row),
    .pull      (joy_mask)
  );

  always_comb begin
    rd_data  = '1;
    rd_drive = '0;
    if (rd_active && color_hit) begin
      rd_drive = COLOR_MASK;
      rd_data  = color_status(sw_color);
    end else if (rd_active && serial_hit) begin
      rd_drive = SERIAL_MASK;
      rd_data  = serial_status(ser_rx_line, ser_cts_in);
    end else if (joy_row) begin
      rd_drive = joy_mask;
      rd_data  = ~joy_mask;
    end
  end

  assign color_en        = cfg.en;
  assign color_attr_mode = cfg.mode;
  assign border_color    = cfg.border;
endmodule

// File: rtl/board_io_checker.sv
module board_io_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic [7:0]  io_wdata,
  input logic        sw_color,
  input logic        sw_serial,
  input logic [7:0]  rd_data,
  input logic [7:0]  rd_drive,
  input logic        color_en,
  input logic        color_attr_mode,
  input logic [3:0]  border_color,
  input logic        ser_tx_line,
  input logic        ser_rts_out,
  input logic        rd_active,
  input logic        wr_active,
  input logic        joy_row
);
  AST_COLOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_active && io_addr == 16'h7FEF && sw_color) |=>
      (color_en == $past(io_wdata[5]) && border_color == $past(io_wdata[3:0]))); // R1

  AST_COLOR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_color |=> (!color_en && !color_attr_mode && border_color == 4'hF)); // R2

  AST_COLOR_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_active && io_addr == 16'h7FEF) |-> rd_drive == 8'h20); // R3

  AST_SERIAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_serial |=> (ser_tx_line && !ser_rts_out)); // R6

  AST_JOY_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    joy_row |-> ((rd_data & rd_drive) == 8'h00)); // R8

  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |-> rd_drive == 8'h00); // R10
endmodule

bind board_io_regs board_io_checker i_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
  .sw_color(sw_color), .sw_serial(sw_serial), .rd_data(rd_data),
  .rd_drive(rd_drive), .color_en(color_en), .color_attr_mode(color_attr_mode),
  .border_color(border_color), .ser_tx_line(ser_tx_line),
  .ser_rts_out(ser_rts_out), .rd_active(rd_active), .wr_active(wr_active),
  .joy_row(joy_row)
);

// File: tb/test_board_io_regs.sv
module test_board_io_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic [7:0]  io_wdata = 8'h00;
  logic        iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        sw_color = 1'b1, sw_serial = 1'b1;
  logic [4:0]  joy_btn = 5'h00;
  logic        ser_rx_line = 1'b1, ser_cts_in = 1'b1;
  logic [7:0]  rd_data, rd_drive;
  logic        color_en, color_attr_mode, ser_tx_line, ser_rts_out;
  logic [3:0]  border_color;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  board_io_regs i_board_io_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .sw_color(sw_color),
    .sw_serial(sw_serial), .joy_btn(joy_btn), .ser_rx_line(ser_rx_line),
    .ser_cts_in(ser_cts_in), .rd_data(rd_data), .rd_drive(rd_drive),
    .color_en(color_en), .color_attr_mode(color_attr_mode),
    .border_color(border_color), .ser_tx_line(ser_tx_line),
    .ser_rts_out(ser_rts_out)
  );

  typedef struct packed {
    logic [15:0] addr;
    logic [4:0]  joy;     // fire,up,down,left,right
    logic        sw6, sw5, rx, cts;
    logic [7:0]  exp_d, exp_m;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{16'h7FEF, 5'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'hDF, 8'h20, 4'd3},  // R3 available
    '{16'h7FEF, 5'h00, 1'b0, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h20, 4'd3},  // R3 not available
    '{16'hFEEF, 5'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h7E, 8'hC1, 4'd5},  // R5 idle line, cts
    '{16'hFEEF, 5'h00, 1'b1, 1'b1, 1'b0, 1'b0, 8'hBE, 8'hC1, 4'd5},  // R5 space, no cts
    '{16'hFEEF, 5'h00, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 4'd4},  // R4 port off
    '{16'hFEFF, 5'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 4'd4},  // R4 full decode
    '{16'hF7FE, 5'h02, 1'b1, 1'b1, 1'b1, 1'b1, 8'hEF, 8'h10, 4'd7},  // R7 left row
    '{16'hF7FE, 5'h1D, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 4'd7},  // R7 other row buttons
    '{16'hEFFE, 5'h1D, 1'b1, 1'b1, 1'b1, 1'b1, 8'hE2, 8'h1D, 4'd7},  // R7 right/up/down/fire
    '{16'hEFFE, 5'h02, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 4'd7},  // R7 left not here
    '{16'hE7FE, 5'h1F, 1'b1, 1'b1, 1'b1, 1'b1, 8'hE2, 8'h1D, 4'd7},  // R7 both rows
    '{16'hFFFE, 5'h1F, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 4'd10}, // R10 no row
    '{16'hF7FF, 5'h02, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 4'd10}, // R10 A0 high
    '{16'hEFFE, 5'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 8'h00, 4'd8}   // R8 nothing pressed
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; iorq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
    #2;
  endtask

  task automatic set_read(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; iorq_n = 1'b0; rd_n = 1'b0;
    #2;
  endtask

  task automatic end_read();
    iorq_n = 1'b1; rd_n = 1'b1;
  endtask

  function automatic logic [7:0] cstate();
    return {2'b00, color_en, color_attr_mode, border_color};
  endfunction

  function automatic logic [7:0] sstate();
    return {6'b0, ser_rts_out, ser_tx_line};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #2;
    check("R9 reset colour", cstate(), 8'h0F);
    check("R6 reset serial idle", sstate(), 8'h01);
    rst_n = 1'b1;

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      joy_btn = VT[i].joy; sw_color = VT[i].sw6; sw_serial = VT[i].sw5;
      ser_rx_line = VT[i].rx; ser_cts_in = VT[i].cts;
      set_read(VT[i].addr);
      check($sformatf("R%0d data vec %0d", VT[i].req, i), rd_data, VT[i].exp_d);
      check($sformatf("R%0d drive vec %0d", VT[i].req, i), rd_drive, VT[i].exp_m);
      end_read();
    end
    joy_btn = 5'h00; sw_color = 1'b1; sw_serial = 1'b1;
    ser_rx_line = 1'b1; ser_cts_in = 1'b1;

    // R10: no read strobe, address on a port
    @(negedge clk); io_addr = 16'h7FEF; iorq_n = 1'b0; rd_n = 1'b1; #2;
    check("R10 no read no drive", rd_drive, 8'h00);
    iorq_n = 1'b1;

    // R1 colour writes
    @(negedge clk); sw_color = 1'b1;
    repeat (2) @(negedge clk);
    io_write(16'h7FEF, 8'h3A);
    check("R1 write 3A", cstate(), 8'h3A);
    io_write(16'h7FEF, 8'hE5);
    check("R1 write E5 upper bits dropped", cstate(), 8'h25);
    io_write(16'h7FEE, 8'h1C);
    check("R1 other address ignored", cstate(), 8'h25);

    // R2 lock
    @(negedge clk); sw_color = 1'b0;
    @(negedge clk); #2;
    check("R2 locked value", cstate(), 8'h0F);
    io_write(16'h7FEF, 8'h3A);
    check("R2 write while locked", cstate(), 8'h0F);
    @(negedge clk); sw_color = 1'b1;
    @(negedge clk); #2;
    check("R2 stays locked value after unlock", cstate(), 8'h0F);
    io_write(16'h7FEF, 8'h16);
    check("R1 write after unlock", cstate(), 8'h16);

    // R4 serial writes
    io_write(16'hFEEF, 8'h03);
    check("R4 data and handshake", sstate(), 8'h02);
    io_write(16'hFEEF, 8'hFE);
    check("R4 handshake only", sstate(), 8'h03);
    io_write(16'hFEED, 8'h01);
    check("R4 partial address ignored", sstate(), 8'h03);
    io_write(16'hFEEF, 8'h01);
    check("R4 data only", sstate(), 8'h00);

    // R6 switch off idles and blocks writes
    @(negedge clk); sw_serial = 1'b0;
    @(negedge clk); #2;
    check("R6 idle when switched off", sstate(), 8'h01);
    io_write(16'hFEEF, 8'h03);
    check("R6 write ignored when off", sstate(), 8'h01);
    @(negedge clk); sw_serial = 1'b1;
    io_write(16'hFEEF, 8'h03);
    check("R4 write after re-enable", sstate(), 8'h02);

    // R6 / R9 reset mid-run
    @(negedge clk); rst_n = 1'b0; #2;
    check("R6 reset idles serial", sstate(), 8'h01);
    check("R9 reset restores colour", cstate(), 8'h0F);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule